// File: doc/BRIEF.md
# Strap Latch and Frequency Mode Decoder

This block captures the board-level configuration straps of a clock generator once and turns them into the active frequency configuration. The two processor frequency-select pins and four single-bit select straps are sampled together the first time the active-low power-good qualifier is seen low. This happens either on its falling level after reset or in the first cycles after reset release if the qualifier is already low. After that capture, later changes on the pins have no effect until the next reset.

The processor frequency code is a 3-bit index. It is formed from a register test bit and the two latched frequency-select pins. The block also gives the frequency in MHz for that index. When a function-select register bit turns the shared power-down pin into an active-low safe-frequency input, holding that pin low forces the fixed safe index. The block also drives the serial-reference, peripheral, USB and shared-output select lines. It assembles the read-only status byte that the register interface returns. A register write to the serial-reference frequency bit takes precedence over its strap from the first write after reset.

The qualifier and the safe-frequency pin are asynchronous to the block clock. They pass through a synchronizer of `SYNC_STAGES` flops. The straps themselves are assumed static while the qualifier falls.

Top module: `fsel_strap_decoder`

## Requirements
- R1: After reset and before any capture, the outputs are as follows. `straps_valid_o`=0. `cpu_code_o`={test_mode_i,0,0}. Every select output is 0. `status_o` bits 0,1,2 and 7..4 read 0.
- R2: The first capture takes place `SYNC_STAGES`+1 rising edges after `pwrgd_ni` is driven low. It stores FS_A, FS_B and the four straps and sets `straps_valid_o`. Later changes on those pins, or on `pwrgd_ni`, have no effect until reset.
- R3: If `pwrgd_ni` is already low during reset, the capture happens `SYNC_STAGES`+1 edges after reset release.
- R4: When not in safe mode, `cpu_code_o` = {test_mode_i, latched FS_A, latched FS_B}. `cpu_mhz_o` maps the code as follows: 0→100, 1→200, 2→133, 3→166, 4→200, 5→400, 6→266, 7→333.
- R5: The bits of `status_o` are assigned as follows. Bit 0 is the latched FS_A. Bit 1 is the latched FS_B. Bit 3 is the live level of `pstop_ni`. Bits 2 and 7..4 read 0.
- R6: The select outputs follow the latched straps with the same polarity. `src_200_o`=1 means 200 MHz (0 is 100). `pci_25_o`=1 means 25 MHz (0 is 33). `usb_24_o`=1 means 24 MHz (0 is 48). `shr_48_o`=1 means 48 MHz (0 is 66.66).
- R7: With `safe_sel_i`=1, a low on `pd_safe_ni` forces `cpu_code_o`=000 and `cpu_mhz_o`=100 within `SYNC_STAGES` edges. The code returns to the latched value after the pin goes high. With `safe_sel_i`=0, the pin has no effect on the code.
- R8: A pulse on `src_wr_i` loads `src_wdata_i` (0=100, 1=200), and from the next edge `src_200_o` follows that value instead of the strap. Reset clears this override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fs_a_i | input | 1 | Processor frequency-select pin A |
| fs_b_i | input | 1 | Processor frequency-select pin B |
| pwrgd_ni | input | 1 | Active-low power-good qualifier (asynchronous) |
| strap_src_i | input | 1 | Serial-reference 100/200 strap |
| strap_pci_i | input | 1 | Peripheral 33/25 strap |
| strap_usb_i | input | 1 | USB 48/24 strap |
| strap_shr_i | input | 1 | Shared-output 66/48 strap |
| test_mode_i | input | 1 | Register test bit, MSB of the frequency index |
| safe_sel_i | input | 1 | Register bit: shared pin acts as safe-frequency input |
| pd_safe_ni | input | 1 | Shared power-down / safe-frequency pin (asynchronous) |
| pstop_ni | input | 1 | Peripheral-stop pin, reported live |
| src_wr_i | input | 1 | Write strobe for the serial-reference frequency bit |
| src_wdata_i | input | 1 | Written serial-reference frequency value |
| cpu_code_o | output | 3 | Active processor frequency index |
| cpu_mhz_o | output | 10 | Processor frequency in MHz |
| src_200_o | output | 1 | Serial reference at 200 MHz |
| pci_25_o | output | 1 | Peripheral clock at 25 MHz |
| usb_24_o | output | 1 | USB clock at 24 MHz |
| shr_48_o | output | 1 | Shared output at 48 MHz |
| straps_valid_o | output | 1 | Straps have been captured |
| status_o | output | 8 | Read-only status byte |

## Verification
On every cycle, the assertions check the following. Once a capture is held, it stays held and the reported FS bits do not move. Outside safe mode, the code is built from the test bit and the reported FS bits. The safe mode forces index 000 at 100 MHz. A register write becomes visible on the serial-reference select on the next edge. The reserved status bits stay zero.

Some behaviours can only be shown by the bench scenarios. These are the exact capture latency after the qualifier falls or after reset release, and the fact that pins changed after capture are ignored. The bench also covers the full frequency table across all FS pin combinations, the strap polarities, and the case where the safe pin is ignored while the function-select bit is 0.

// File: rtl/fsel_pkg.sv
package fsel_pkg;
  localparam int CODE_W = 3;
  localparam int MHZ_W  = 10;
  localparam logic [CODE_W-1:0] SAFE_CODE = 3'b000;

  typedef struct packed {
    logic fs_a;
    logic fs_b;
    logic src;
    logic pci;
    logic usb;
    logic shr;
  } strap_t;

  function automatic logic [MHZ_W-1:0] code_to_mhz(input logic [CODE_W-1:0] code);
    logic [MHZ_W-1:0] base;
    // low two bits pick the base rate, bit 2 doubles it (except the 166 -> 333 row)
    case (code[1:0])
      2'd0:    base = 10'd100;
      2'd1:    base = 10'd200;
      2'd2:    base = 10'd133;
      default: base = 10'd166;
    endcase
    if (!code[2])                 code_to_mhz = base;
    else if (code[1:0] == 2'd0)   code_to_mhz = 10'd200;
    else if (code[1:0] == 2'd3)   code_to_mhz = 10'd333;
    else                          code_to_mhz = base << 1;
  endfunction
endpackage

// File: rtl/fsel_sync.sv
module fsel_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch
  import fsel_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pwrgd_s_ni,
  input  strap_t pins_i,
  output strap_t latched_o,
  output logic   valid_o
);
  strap_t lat_q;
  logic   vld_q;

  // one-shot capture: first synchronized low of the qualifier
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      vld_q <= 1'b0;
    end else if (!vld_q && !pwrgd_s_ni) begin
      lat_q <= pins_i;
      vld_q <= 1'b1;
    end
  end

  assign latched_o = lat_q;
  assign valid_o   = vld_q;
endmodule

// File: rtl/fsel_src_ovr.sv
module fsel_src_ovr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  logic wdata_i,
  output logic vld_o,
  output logic val_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      val_o <= 1'b0;
    end else if (wr_i) begin
      vld_o <= 1'b1;
      val_o <= wdata_i;
    end
  end
endmodule

// File: rtl/fsel_mode_decode.sv
module fsel_mode_decode
  import fsel_pkg::*;
(
  input  strap_t              lat_i,
  input  logic                test_i,
  input  logic                safe_act_i,
  input  logic                ovr_vld_i,
  input  logic                ovr_val_i,
  input  logic                pstop_ni,
  output logic [CODE_W-1:0]   code_o,
  output logic [MHZ_W-1:0]    mhz_o,
  output logic                src_200_o,
  output logic                pci_25_o,
  output logic                usb_24_o,
  output logic                shr_48_o,
  output logic [7:0]          status_o
);
  always_comb begin
    code_o    = safe_act_i ? SAFE_CODE : {test_i, lat_i.fs_a, lat_i.fs_b};
    mhz_o     = code_to_mhz(code_o);
    src_200_o = ovr_vld_i ? ovr_val_i : lat_i.src;
    pci_25_o  = lat_i.pci;
    usb_24_o  = lat_i.usb;
    shr_48_o  = lat_i.shr;
    status_o  = {4'b0000, pstop_ni, 1'b0, lat_i.fs_b, lat_i.fs_a};
  end
endmodule

// File: rtl/fsel_strap_decoder.sv
module fsel_strap_decoder
  import fsel_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fs_a_i,
  input  logic              fs_b_i,
  input  logic              pwrgd_ni,
  input  logic              strap_src_i,
  input  logic              strap_pci_i,
  input  logic              strap_usb_i,
  input  logic              strap_shr_i,
  input  logic              test_mode_i,
  input  logic              safe_sel_i,
  input  logic              pd_safe_ni,
  input  logic              pstop_ni,
  input  logic              src_wr_i,
  input  logic              src_wdata_i,
  output logic [CODE_W-1:0] cpu_code_o,
  output logic [MHZ_W-1:0]  cpu_mhz_o,
  output logic              src_200_o,
  output logic              pci_25_o,
  output logic              usb_24_o,
  output logic              shr_48_o,
  output logic              straps_valid_o,
  output logic [7:0]        status_o
);
  logic [1:0] async_s;
  logic       pwrgd_s_n;
  logic       pd_safe_s_n;
  logic       safe_act;
  strap_t     pins;
  strap_t     lat;
  logic       ovr_vld;
  logic       ovr_val;

  fsel_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({pwrgd_ni, pd_safe_ni}),
    .q_o   (async_s)
  );
  assign pwrgd_s_n   = async_s[1];
  assign pd_safe_s_n = async_s[0];
  assign safe_act    = safe_sel_i & ~pd_safe_s_n;

  assign pins = '{fs_a: fs_a_i, fs_b: fs_b_i, src: strap_src_i,
                  pci: strap_pci_i, usb: strap_usb_i, shr: strap_shr_i};

  fsel_strap_latch u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwrgd_s_ni(pwrgd_s_n),
    .pins_i    (pins),
    .latched_o (lat),
    .valid_o   (straps_valid_o)
  );

  fsel_src_ovr u_ovr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (src_wr_i),
    .wdata_i(src_wdata_i),
    .vld_o  (ovr_vld),
    .val_o  (ovr_val)
  );

  fsel_mode_decode u_dec (
    .lat_i     (lat),
    .test_i    (test_mode_i),
    .safe_act_i(safe_act),
    .ovr_vld_i (ovr_vld),
    .ovr_val_i (ovr_val),
    .pstop_ni  (pstop_ni),
    .code_o    (cpu_code_o),
    .mhz_o     (cpu_mhz_o),
    .src_200_o (src_200_o),
    .pci_25_o  (pci_25_o),
    .usb_24_o  (usb_24_o),
    .shr_48_o  (shr_48_o),
    .status_o  (status_o)
  );
endmodule

// File: rtl/fsel_strap_decoder_chk.sv
module fsel_strap_decoder_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       test_mode_i,
  input logic       src_wr_i,
  input logic       src_wdata_i,
  input logic       safe_act,
  input logic [2:0] cpu_code_o,
  input logic [9:0] cpu_mhz_o,
  input logic       src_200_o,
  input logic       straps_valid_o,
  input logic [7:0] status_o
);
  a_r2_capture_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    straps_valid_o |=> straps_valid_o && $stable(status_o[1:0]));

  a_r4_code_from_fs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !safe_act |-> cpu_code_o == {test_mode_i, status_o[0], status_o[1]});

  a_r7_safe_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    safe_act |-> cpu_code_o == 3'b000 && cpu_mhz_o == 10'd100);

  a_r8_src_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_wr_i |=> src_200_o == $past(src_wdata_i));

  a_r5_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[7:4] == 4'b0000 && status_o[2] == 1'b0);
endmodule

bind fsel_strap_decoder fsel_strap_decoder_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .test_mode_i   (test_mode_i),
  .src_wr_i      (src_wr_i),
  .src_wdata_i   (src_wdata_i),
  .safe_act      (safe_act),
  .cpu_code_o    (cpu_code_o),
  .cpu_mhz_o     (cpu_mhz_o),
  .src_200_o     (src_200_o),
  .straps_valid_o(straps_valid_o),
  .status_o      (status_o)
);

// File: tb/fsel_strap_decoder_bench.sv
module fsel_strap_decoder_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fs_a = 0, fs_b = 0, pwrgd_n = 1;
  logic s_src = 0, s_pci = 0, s_usb = 0, s_shr = 0;
  logic test_m = 0, safe_sel = 0, pd_safe_n = 1, pstop_n = 1;
  logic src_wr = 0, src_wd = 0;
  logic [2:0] code;
  logic [9:0] mhz;
  logic src_200, pci_25, usb_24, shr_48, vld;
  logic [7:0] status;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fsel_strap_decoder u_fsel_strap_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .fs_a_i(fs_a), .fs_b_i(fs_b), .pwrgd_ni(pwrgd_n),
    .strap_src_i(s_src), .strap_pci_i(s_pci), .strap_usb_i(s_usb), .strap_shr_i(s_shr),
    .test_mode_i(test_m), .safe_sel_i(safe_sel), .pd_safe_ni(pd_safe_n), .pstop_ni(pstop_n),
    .src_wr_i(src_wr), .src_wdata_i(src_wd),
    .cpu_code_o(code), .cpu_mhz_o(mhz), .src_200_o(src_200), .pci_25_o(pci_25),
    .usb_24_o(usb_24), .shr_48_o(shr_48), .straps_valid_o(vld), .status_o(status)
  );

  function automatic int exp_mhz(input int idx);
    case (idx)
      0: return 100; 1: return 200; 2: return 133; 3: return 166;
      4: return 200; 5: return 400; 6: return 266; default: return 333;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic pg_low);
    @(negedge clk);
    rst_ni = 1'b0;
    pwrgd_n = ~pg_low;
    wait_neg(3);
    rst_ni = 1'b1;
  endtask

  task automatic t_reset_state;
    do_reset(1'b0);
    wait_neg(4);
    check("R1 valid", vld, 0);
    check("R1 code", code, 0);
    check("R1 selects", {src_200, pci_25, usb_24, shr_48}, 0);
    check("R1 status", status, 8'h08);
    test_m = 1; #1;
    check("R1 code test bit", code, 4);
    test_m = 0;
  endtask

  task automatic t_capture;
    fs_a = 1; fs_b = 0; s_src = 1; s_pci = 0; s_usb = 1; s_shr = 0;
    pwrgd_n = 0;
    wait_neg(2);
    check("R2 not yet captured", vld, 0);
    wait_neg(1);
    check("R2 captured", vld, 1);
    check("R4 code", code, 2);
    check("R4 mhz", mhz, 133);
    check("R5 status", status, 8'h09);
    check("R6 selects", {src_200, pci_25, usb_24, shr_48}, 4'b1010);
    fs_a = 0; fs_b = 1; s_src = 0; s_pci = 1; s_usb = 0; s_shr = 1;
    pwrgd_n = 1; wait_neg(4); pwrgd_n = 0; wait_neg(4);
    check("R2 ignored code", code, 2);
    check("R2 ignored selects", {src_200, pci_25, usb_24, shr_48}, 4'b1010);
    check("R2 ignored status", status, 8'h09);
  endtask

  task automatic t_table;
    for (int f = 0; f < 4; f++) begin
      fs_a = f[1]; fs_b = f[0];
      s_src = 0; s_pci = f[0]; s_usb = f[1]; s_shr = ~f[0];
      do_reset(1'b0);
      pwrgd_n = 0;
      wait_neg(4);
      for (int t = 0; t < 2; t++) begin
        test_m = t[0]; #1;
        check("R4 table code", code, t * 4 + f);
        check("R4 table mhz", mhz, exp_mhz(t * 4 + f));
      end
      test_m = 0;
      check("R6 pci/usb/shr", {pci_25, usb_24, shr_48}, {f[0], f[1], ~f[0]});
    end
  endtask

  task automatic t_reset_low;
    fs_a = 1; fs_b = 1; s_shr = 1;
    do_reset(1'b1);
    wait_neg(2);
    check("R3 not yet captured", vld, 0);
    wait_neg(1);
    check("R3 captured", vld, 1);
    check("R3 code", code, 3);
    check("R3 shr", shr_48, 1);
  endtask

  task automatic t_safe;
    test_m = 1;
    safe_sel = 0; pd_safe_n = 0; wait_neg(4);
    check("R7 ignored when not selected", code, 7);
    safe_sel = 1; wait_neg(3);
    check("R7 safe code", code, 0);
    check("R7 safe mhz", mhz, 100);
    check("R5 status in safe", status[1:0], 2'b11);
    pd_safe_n = 1; wait_neg(3);
    check("R7 restored", code, 7);
    check("R7 restored mhz", mhz, 333);
    safe_sel = 0; test_m = 0;
  endtask

  task automatic t_pstop;
    pstop_n = 0; #1;
    check("R5 pstop low", status[3], 0);
    pstop_n = 1; #1;
    check("R5 pstop high", status[3], 1);
  endtask

  task automatic t_src;
    s_src = 1; fs_a = 0; fs_b = 0;
    do_reset(1'b1);
    wait_neg(4);
    check("R8 strap before write", src_200, 1);
    src_wr = 1; src_wd = 0; wait_neg(1); src_wr = 0;
    check("R8 write 0", src_200, 0);
    wait_neg(2);
    check("R8 write held", src_200, 0);
    src_wr = 1; src_wd = 1; wait_neg(1); src_wr = 0;
    check("R8 write 1", src_200, 1);
    s_src = 0;
    do_reset(1'b1);
    wait_neg(4);
    check("R8 cleared by reset", src_200, 0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_capture();
    t_table();
    t_reset_low();
    t_safe();
    t_pstop();
    t_src();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule